// File: doc/BRIEF.md
# FIR Accumulator Output Stage

This block is the result section of a multi-cell FIR engine. Eight multiply-accumulate cells each hold a 26-bit running sum, and a 3-bit cell address picks one of them. Each clock the stage shows one of two values on a 26-bit result bus: the addressed cell, read with a hold-on-first-select rule, or an output buffer register. The choice depends on a shift-add control input over two successive clocks.

The output buffer loads the addressed cell result every clock. When shift-add is active, the load also adds the buffer's own previous value, arithmetically shifted right by 8 bits. This lets a long product sum be built from partial sums at extended precision. The cell address, the shift-add control and the reset input each pass through one register before use. Reading one address for several clocks keeps the value captured on the first clock, so a slow memory can sample a steady word.

The result bus is split into a low group (bits 15:0) and a high group (bits 25:16), each with its own active-low enable. Each group has an output-enable signal that stands in for a tri-state driver. A 16-bit side port gives the view for a narrow host bus: the low group, or the high group sign-extended to 16 bits.

Top module: `fir_out_stage`

## Requirements
- R1: The cell address, the shift-add control and the active-low reset are each sampled by one register at a clock edge. A value driven before edge k governs the stage from edge k onward. A reset driven low before edge k clears state at edge k+1.
- R2: The bus shows the addressed cell path only when the registered shift-add is low and was also low at the previous edge. Otherwise it shows the output buffer.
- R3: After the registered address changes, or on the first clock after reset, the cell path shows the live addressed cell. While the registered address stays the same, the cell path keeps that first value, even if the cell changes.
- R4: At every edge out of reset, the buffer loads the live addressed cell plus an operand. The operand is the buffer shifted right by 8 when the registered shift-add is high, and zero when it is low. The sum wraps modulo 2^26.
- R5: When the registered reset is low, the buffer and hold state are cleared and the shift-add history is set high, so the bus reads zero.
- R6: With the low enable (active low) at 0, sum_o[15:0] carries bus bits 15:0 and oe_lo_o is 1. With the low enable at 1, sum_o[15:0] is 0 and oe_lo_o is 0.
- R7: With the high enable (active low) at 0, sum_o[25:16] carries bus bits 25:16 and oe_hi_o is 1. With the high enable at 1, sum_o[25:16] is 0 and oe_hi_o is 0.
- R8: narrow_o is bus bits 15:0 when the low enable is 0. Otherwise it is bus bits 25:16 sign-extended from bit 25 to 16 bits when the high enable is 0. Otherwise it is 0.
- R9: The shift by 8 in R4 is arithmetic. The 8 upper operand bits copy buffer bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, registered once before use |
| cell_flat_i | input | 208 | Eight 26-bit cell results; cell n at bits 26n+25:26n |
| addr_i | input | 3 | Cell address |
| shadd_i | input | 1 | Shift-add control, active high |
| en_lo_n_i | input | 1 | Active-low enable for result bits 15:0 |
| en_hi_n_i | input | 1 | Active-low enable for result bits 25:16 |
| sum_o | output | 26 | Result bus; disabled groups read zero |
| oe_lo_o | output | 1 | Low group driven |
| oe_hi_o | output | 1 | High group driven |
| narrow_o | output | 16 | 16-bit view: low group, or sign-extended high group |

## Verification
The assertions check on every cycle that the bus source follows the two-clock shift-add history, and that the buffer takes the expected sum after each edge. They also check that a held address in cell mode keeps the bus steady, that reset clears the buffer, and that the group gating and the narrow view are correct. Only the bench's scenarios show the end-to-end timing through the input registers. Those scenarios also cover extended-precision accumulation over several clocks with negative buffer values, and a frozen cell read while the cell contents keep changing.

// File: rtl/fir_out_pkg.sv
// Shared sizes and the result type for the FIR output stage.
// Assumes a single clock domain; all widths derive from these defaults.
package fir_out_pkg;
    localparam int unsigned ACC_W   = 26;
    localparam int unsigned N_CELLS = 8;
    localparam int unsigned SHIFT   = 8;
    localparam int unsigned LOW_W   = 16;
    typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/fir_out_ctl.sv
// Input register stage: samples reset, address and shift-add once,
// and keeps one extra clock of shift-add history.
// Assumes rst_n is synchronous; the registered copy drives all resets.
module fir_out_ctl #(
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          shadd_i,
    output logic          rst_q,
    output logic [AW-1:0] addr_q,
    output logic          shadd_q,
    output logic          shadd_qq
);
    // Register the reset input itself.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    // Register address and shift-add, and age shift-add by one clock.
    always_ff @(posedge clk) begin
        if (!rst_q) begin
            addr_q   <= '0;
            shadd_q  <= 1'b1;
            shadd_qq <= 1'b1;
        end else begin
            addr_q   <= addr_i;
            shadd_q  <= shadd_i;
            shadd_qq <= shadd_q;
        end
    end
endmodule

// File: rtl/fir_out_hold.sv
// Cell selector with hold-on-first-select: the first clock an address
// is seen shows the live cell, later clocks repeat that captured value.
// Assumes cells are packed cell n at bits n*W +: W.
module fir_out_hold #(
    parameter int unsigned W  = 26,
    parameter int unsigned NC = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_q,
    input  logic [NC*W-1:0] cell_flat_i,
    input  logic [AW-1:0] addr_q,
    output logic [W-1:0]  live_o,
    output logic [W-1:0]  view_o,
    output logic          valid_o
);
    logic [W-1:0]  hold_q;
    logic [AW-1:0] prev_q;
    logic          fresh;

    // Pick the addressed cell from the packed input.
    always_comb begin
        live_o = cell_flat_i[addr_q*W +: W];
    end

    // Show live value on a new address, else the captured one.
    always_comb begin
        fresh  = !valid_o || (addr_q != prev_q);
        view_o = fresh ? live_o : hold_q;
    end

    // Capture the shown value and remember the address.
    always_ff @(posedge clk) begin
        if (!rst_q) begin
            hold_q  <= '0;
            prev_q  <= '0;
            valid_o <= 1'b0;
        end else begin
            hold_q  <= view_o;
            prev_q  <= addr_q;
            valid_o <= 1'b1;
        end
    end
endmodule

// File: rtl/fir_out_sadd.sv
// Output buffer with shift-add: loads cell + (buffer >>> SH) when
// shift-add is active, or the cell alone otherwise.
// Assumes two's complement values and wrap-around on overflow.
module fir_out_sadd #(
    parameter int unsigned W  = 26,
    parameter int unsigned SH = 8
) (
    input  logic         clk,
    input  logic         rst_q,
    input  logic         shadd_q,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] buf_o
);
    logic [W-1:0] operand;

    // Arithmetic right shift of the buffer, or zero.
    always_comb begin
        if (shadd_q) operand = {{SH{buf_o[W-1]}}, buf_o[W-1:SH]};
        else         operand = '0;
    end

    // Load the buffer every clock.
    always_ff @(posedge clk) begin
        if (!rst_q) buf_o <= '0;
        else        buf_o <= live_i + operand;
    end
endmodule

// File: rtl/fir_out_drive.sv
// Bus source mux and the two group drivers, plus the 16-bit view.
// Assumes disabled groups read as zero (no tri-state on chip).
module fir_out_drive #(
    parameter int unsigned W  = 26,
    parameter int unsigned LW = 16
) (
    input  logic         shadd_q,
    input  logic         shadd_qq,
    input  logic [W-1:0] view_i,
    input  logic [W-1:0] buf_i,
    input  logic         en_lo_n_i,
    input  logic         en_hi_n_i,
    output logic [W-1:0] bus_o,
    output logic [W-1:0] sum_o,
    output logic         oe_lo_o,
    output logic         oe_hi_o,
    output logic [LW-1:0] narrow_o
);
    localparam int unsigned HW = W - LW;

    // Cell path only after two low shift-add samples.
    always_comb begin
        bus_o = (!shadd_q && !shadd_qq) ? view_i : buf_i;
    end

    // Group gating of the wide bus.
    always_comb begin
        oe_lo_o = !en_lo_n_i;
        oe_hi_o = !en_hi_n_i;
        sum_o[LW-1:0] = oe_lo_o ? bus_o[LW-1:0] : '0;
        sum_o[W-1:LW] = oe_hi_o ? bus_o[W-1:LW] : '0;
    end

    // Narrow view: low group first, else sign-extended high group.
    always_comb begin
        if (oe_lo_o)      narrow_o = bus_o[LW-1:0];
        else if (oe_hi_o) narrow_o = {{(LW-HW){bus_o[W-1]}}, bus_o[W-1:LW]};
        else              narrow_o = '0;
    end
endmodule

// File: rtl/fir_out_stage.sv
// Top of the FIR output stage: input registers, held cell reader,
// shift-add buffer and group drivers.
// Assumes one clock; reset is synchronous, active low, registered once.
module fir_out_stage
    import fir_out_pkg::*;
#(
    parameter int unsigned W  = ACC_W,
    parameter int unsigned NC = N_CELLS,
    parameter int unsigned SH = SHIFT,
    parameter int unsigned LW = LOW_W,
    localparam int unsigned AW = $clog2(NC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NC*W-1:0] cell_flat_i,
    input  logic [AW-1:0]  addr_i,
    input  logic           shadd_i,
    input  logic           en_lo_n_i,
    input  logic           en_hi_n_i,
    output logic [W-1:0]   sum_o,
    output logic           oe_lo_o,
    output logic           oe_hi_o,
    output logic [LW-1:0]  narrow_o
);
    logic          rst_q;
    logic [AW-1:0] addr_q;
    logic          shadd_q;
    logic          shadd_qq;
    logic [W-1:0]  live_w;
    logic [W-1:0]  view_w;
    logic          valid_w;
    logic [W-1:0]  buf_w;
    logic [W-1:0]  bus_w;

    fir_out_ctl #(.AW(AW)) ctl_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .shadd_i(shadd_i),
        .rst_q(rst_q), .addr_q(addr_q), .shadd_q(shadd_q), .shadd_qq(shadd_qq)
    );

    fir_out_hold #(.W(W), .NC(NC), .AW(AW)) hold_i (
        .clk(clk), .rst_q(rst_q), .cell_flat_i(cell_flat_i), .addr_q(addr_q),
        .live_o(live_w), .view_o(view_w), .valid_o(valid_w)
    );

    fir_out_sadd #(.W(W), .SH(SH)) sadd_i (
        .clk(clk), .rst_q(rst_q), .shadd_q(shadd_q), .live_i(live_w),
        .buf_o(buf_w)
    );

    fir_out_drive #(.W(W), .LW(LW)) drive_i (
        .shadd_q(shadd_q), .shadd_qq(shadd_qq), .view_i(view_w), .buf_i(buf_w),
        .en_lo_n_i(en_lo_n_i), .en_hi_n_i(en_hi_n_i), .bus_o(bus_w),
        .sum_o(sum_o), .oe_lo_o(oe_lo_o), .oe_hi_o(oe_hi_o), .narrow_o(narrow_o)
    );
endmodule

// File: rtl/fir_out_stage_chk.sv
// Property checker for fir_out_stage, attached by bind below.
// Assumes the top's default widths (26-bit bus, 16-bit low group, shift 8).
module fir_out_stage_chk (
    input logic        clk,
    input logic        rst_q,
    input logic [2:0]  addr_q,
    input logic        shadd_q,
    input logic        shadd_qq,
    input logic        valid_w,
    input logic [25:0] live_w,
    input logic [25:0] buf_w,
    input logic [25:0] bus_w,
    input logic [25:0] sum_o,
    input logic        en_lo_n_i,
    input logic        en_hi_n_i,
    input logic        oe_lo_o,
    input logic        oe_hi_o,
    input logic [15:0] narrow_o
);
    // R2
    bus_src_chk: assert property (@(posedge clk) disable iff (!rst_q)
        (shadd_q || shadd_qq) |-> (bus_w == buf_w));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
        ($past(rst_q) && valid_w && $past(valid_w) && (addr_q == $past(addr_q))
         && !shadd_q && !shadd_qq && !$past(shadd_q) && !$past(shadd_qq))
        |-> $stable(bus_w));

    // R4
    buf_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
        ($past(rst_q) && !$past(shadd_q)) |-> (buf_w == $past(live_w)));

    // R5
    reset_chk: assert property (@(posedge clk)
        $past(rst_q) == 1'b0 |-> (buf_w == 26'd0));

    // R6
    lo_grp_chk: assert property (@(posedge clk)
        (sum_o[15:0] == (en_lo_n_i ? 16'd0 : bus_w[15:0])) && (oe_lo_o == !en_lo_n_i));

    // R7
    hi_grp_chk: assert property (@(posedge clk)
        (sum_o[25:16] == (en_hi_n_i ? 10'd0 : bus_w[25:16])) && (oe_hi_o == !en_hi_n_i));

    // R8
    narrow_chk: assert property (@(posedge clk)
        (en_lo_n_i && !en_hi_n_i) |-> (narrow_o == {{6{bus_w[25]}}, bus_w[25:16]}));
endmodule

bind fir_out_stage fir_out_stage_chk chk_i (
    .clk(clk), .rst_q(rst_q), .addr_q(addr_q), .shadd_q(shadd_q),
    .shadd_qq(shadd_qq), .valid_w(valid_w), .live_w(live_w), .buf_w(buf_w),
    .bus_w(bus_w), .sum_o(sum_o), .en_lo_n_i(en_lo_n_i), .en_hi_n_i(en_hi_n_i),
    .oe_lo_o(oe_lo_o), .oe_hi_o(oe_hi_o), .narrow_o(narrow_o)
);

// File: tb/fir_out_stage_tb_top.sv
`timescale 1ns/1ps
module fir_out_stage_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [207:0] cell_flat_i = '0;
    logic [2:0]   addr_i = '0;
    logic         shadd_i = 1'b1;
    logic         en_lo_n_i = 1'b0;
    logic         en_hi_n_i = 1'b0;
    logic [25:0]  sum_o;
    logic         oe_lo_o;
    logic         oe_hi_o;
    logic [15:0]  narrow_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [25:0] c [8];

    // Bench model state, written from the requirements.
    bit          m_rstq = 1'b0;
    logic [2:0]  m_addr = '0;
    bit          m_sh = 1'b1, m_shq = 1'b1, m_valid = 1'b0;
    logic [2:0]  m_prev = '0;
    logic [25:0] m_hold = '0, m_buf = '0;

    always #2 clk = ~clk;

    fir_out_stage dut_i (
        .clk(clk), .rst_n(rst_n), .cell_flat_i(cell_flat_i), .addr_i(addr_i),
        .shadd_i(shadd_i), .en_lo_n_i(en_lo_n_i), .en_hi_n_i(en_hi_n_i),
        .sum_o(sum_o), .oe_lo_o(oe_lo_o), .oe_hi_o(oe_hi_o), .narrow_o(narrow_o)
    );

    function automatic logic [25:0] asr8(input logic [25:0] v);
        return {{8{v[25]}}, v[25:8]};
    endfunction

    function automatic logic [25:0] exp_bus();
        logic [25:0] view;
        view = (!m_valid || m_addr != m_prev) ? c[m_addr] : m_hold;
        return (!m_sh && !m_shq) ? view : m_buf;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, mirror the edge in the model, check after.
    task automatic step(input bit r, input logic [2:0] a, input bit s,
                        input bit elo, input bit ehi, input string tag);
        logic [25:0] b, live, view;
        @(negedge clk);
        rst_n = r; addr_i = a; shadd_i = s; en_lo_n_i = elo; en_hi_n_i = ehi;
        for (int i = 0; i < 8; i++) cell_flat_i[i*26 +: 26] = c[i];
        @(posedge clk);
        if (!m_rstq) begin
            m_addr = '0; m_sh = 1; m_shq = 1; m_buf = '0; m_hold = '0;
            m_valid = 0; m_prev = '0;
        end else begin
            live  = c[m_addr];
            view  = (!m_valid || m_addr != m_prev) ? live : m_hold;
            m_hold = view; m_prev = m_addr; m_valid = 1;
            m_buf = live + (m_sh ? asr8(m_buf) : 26'd0);
            m_shq = m_sh; m_sh = s; m_addr = a;
        end
        m_rstq = r;
        #1;
        b = exp_bus();
        chk({tag, " R6 lo"}, {16'd0, sum_o[15:0]}, elo ? 32'd0 : {16'd0, b[15:0]});
        chk({tag, " R7 hi"}, {22'd0, sum_o[25:16]}, ehi ? 32'd0 : {22'd0, b[25:16]});
        chk({tag, " R6 R7 oe"}, {30'd0, oe_hi_o, oe_lo_o}, {30'd0, !ehi, !elo});
        chk({tag, " R8 narrow"}, {16'd0, narrow_o},
            !elo ? {16'd0, b[15:0]} : (!ehi ? {16'd0, {6{b[25]}}, b[25:16]} : 32'd0));
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 8; i++) c[i] = 26'(i * 26'h11111 + 26'h5);
        // R5 reset state: reset registered, bus reads zero
        step(0, 0, 0, 0, 0, "R5 reset");
        step(0, 0, 0, 0, 0, "R5 reset");
        step(1, 3, 0, 0, 0, "R1 release");
        chk("R5 bus zero after reset", {6'd0, sum_o}, 32'd0);
        step(1, 3, 0, 0, 0, "R1 addr");
        step(1, 3, 0, 0, 0, "R2 cell mode");
        chk("R2 cell 3 shown", {6'd0, sum_o}, {6'd0, c[3]});
        // R3 freeze: change cell 3 while address held
        c[3] = 26'h2ABCDEF;
        step(1, 3, 0, 0, 0, "R3 hold");
        step(1, 3, 0, 0, 0, "R3 hold");
        chk("R3 frozen value", {6'd0, sum_o}, {6'd0, 26'(3 * 26'h11111 + 26'h5)});
        step(1, 5, 0, 0, 0, "R3 new addr");
        step(1, 3, 0, 0, 0, "R3 back");
        step(1, 3, 0, 0, 0, "R3 back live");
        chk("R3 refreshed value", {6'd0, sum_o}, {6'd0, c[3]});
        // R4 R9 extended precision with a negative buffer
        c[1] = 26'h3F00000;
        for (int k = 0; k < 6; k++) step(1, 1, 1, 0, 0, "R4 R9 sadd");
        // R2 one low sample is not enough
        step(1, 2, 0, 0, 0, "R2 single low");
        step(1, 2, 1, 0, 0, "R2 back high");
        // R8 narrow groups
        step(1, 1, 1, 1, 0, "R8 high only");
        step(1, 1, 1, 1, 1, "R8 none");
        step(1, 1, 1, 0, 1, "R8 low only");
        // Mid-run reset, R1 one clock of latency on reset
        step(0, 4, 0, 0, 0, "R1 reset req");
        step(1, 4, 0, 0, 0, "R5 cleared");
        chk("R5 mid-run clear", {6'd0, sum_o}, 32'd0);
        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0)
                c[$urandom_range(0, 7)] = 26'($urandom());
            step(($urandom_range(0, 99) != 0), 3'($urandom_range(0, 7) & (n[3] ? 3'd1 : 3'd7)),
                 ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0),
                 ($urandom_range(0, 4) == 0), "R2 R3 R4 random");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule